// File: doc/BRIEF.md
# Two-Step Watchdog Refresh Controller

This block is a watchdog timer behind a byte-wide special-function-register write port. Two control registers sit at addresses 0xA8 and 0xB8. Each holds one watchdog flag in bit 6. Their remaining bits are ordinary interrupt-enable bits, which the block only stores and returns. The interrupt logic that uses those enables lives elsewhere. Setting the kick flag in register 0xB8 starts the watchdog counter when it is idle. Once the counter runs, it is reloaded only when software sets the arm flag in register 0xA8 and makes its very next register write the kick. This makes a stray write from runaway code unlikely to keep the watchdog fed.

Both flags drop back to zero by themselves a fixed number of clocks after software sets them. A running counter that reaches zero drives a one-clock reset pulse and then halts. The only way to stop a running counter is the block's own reset. Read data is combinational from the address, and reads have no side effects. The write port is a plain strobe with no back-pressure: every cycle with the strobe high is one register write.

Top module: `wdog_refresh_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and the watchdog reset output is low.
- R2: Register 0xA8 stores bits 7 and 4..0 as written, and bit 5 reads 0. Register 0xB8 stores bits 5..1 as written, and bits 7 and 0 read 0.
- R3: Writing 1 to bit 6 of 0xA8 (the arm flag) makes it read 1 for the 12 clocks that follow the write edge. It reads 0 from the 12th edge after the write onward.
- R4: The kick flag (bit 6 of 0xB8) clears itself on the same 12-clock schedule.
- R5: A write with bit 6 of 0xB8 set starts an idle counter at TIMEOUT. The reset output goes high at the (TIMEOUT+1)th edge after that write.
- R6: An arm write followed by a kick write as the next write to either register reloads a running counter. The two writes need not be on consecutive clocks, provided the arm flag still reads 1.
- R7: A kick write whose preceding register write was not an arm write does not reload a running counter.
- R8: Any write to 0xA8 or 0xB8 that comes between the arm write and the kick write cancels the refresh.
- R9: A kick written 13 or more clocks after the arm write finds the arm flag cleared and does not reload the counter.
- R10: Writing 0 to either flag bit does not stop or reload a running counter. The counter stops only on timeout or reset.
- R11: The reset output stays high for exactly one clock. The counter then stays idle and gives no further pulse until a new kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Write strobe, one write per cycle it is high |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr, 0 for other addresses |
| wd_rst_o | output | 1 | One-clock watchdog reset pulse |

## Verification
Some properties are checked on every cycle. Neither flag stays high past its 12-clock lifetime. The reset output never lasts two cycles. The counter never leaves the running state without producing the pulse. Every internal refresh comes from an arm write that was the previous register write while the arm flag was still set.

Other behaviour only the bench scenarios can show, because it depends on the exact timeout cycle. These include the reload on a proper sequence, the absence of a reload for a lone kick or an interrupted or stale sequence, and read-back of the enable bits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] ADDR_ARM  = 8'hA8;
  localparam logic [7:0] ADDR_KICK = 8'hB8;
  localparam int         FLAG_POS  = 6;
  localparam logic [7:0] ARM_KEEP  = 8'b1001_1111;
  localparam logic [7:0] KICK_KEEP = 8'b0011_1110;
  localparam int         NFLAG     = 2;
  localparam int         IDX_ARM   = 0;
  localparam int         IDX_KICK  = 1;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
  } sfr_wr_t;
endpackage

// File: rtl/wdog_selfclr_flag.sv
module wdog_selfclr_flag #(
  parameter int HOLD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic bit_i,
  output logic flag_o
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      left_q <= '0;
    end else if (wr_i) begin
      flag_o <= bit_i;
      left_q <= bit_i ? HW'(HOLD) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == HW'(1)) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_arm_seq.sv
module wdog_arm_seq
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sfr_wr_t wr_i,
  input  logic    arm_flag_i,
  output logic    kick_o,
  output logic    refresh_o
);
  logic hit_arm, hit_kick, armed_q;

  assign hit_arm   = wr_i.we && (wr_i.addr == ADDR_ARM);
  assign hit_kick  = wr_i.we && (wr_i.addr == ADDR_KICK);
  assign kick_o    = hit_kick && wr_i.data[FLAG_POS];
  assign refresh_o = kick_o && armed_q && arm_flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed_q <= 1'b0;
    else if (hit_arm || hit_kick) armed_q <= hit_arm && wr_i.data[FLAG_POS];
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 65535
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic refresh_i,
  output logic running_o,
  output logic bite_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             load;

  assign load = refresh_i || (kick_i && !running_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      bite_o    <= 1'b0;
    end else begin
      bite_o <= 1'b0;
      if (load) begin
        cnt_q     <= CNT_W'(TIMEOUT);
        running_o <= 1'b1;
      end else if (running_o) begin
        if (cnt_q == '0) begin
          running_o <= 1'b0;
          bite_o    <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_refresh_ctrl.sv
module wdog_refresh_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TIMEOUT   = 65535,
  parameter int FLAG_HOLD = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       wd_rst_o
);
  sfr_wr_t          wr;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_wr;
  logic [7:0]       en_arm_q, en_kick_q;
  logic             kick, refresh, running;

  assign wr.we   = sfr_we;
  assign wr.addr = sfr_addr;
  assign wr.data = sfr_wdata;

  assign flag_wr[IDX_ARM]  = sfr_we && (sfr_addr == ADDR_ARM);
  assign flag_wr[IDX_KICK] = sfr_we && (sfr_addr == ADDR_KICK);

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      wdog_selfclr_flag #(.HOLD(FLAG_HOLD)) u_flag (
        .clk(clk), .rst_n(rst_n), .wr_i(flag_wr[i]),
        .bit_i(sfr_wdata[FLAG_POS]), .flag_o(flag_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_arm_q  <= '0;
      en_kick_q <= '0;
    end else begin
      if (flag_wr[IDX_ARM])  en_arm_q  <= sfr_wdata & ARM_KEEP;
      if (flag_wr[IDX_KICK]) en_kick_q <= sfr_wdata & KICK_KEEP;
    end
  end

  wdog_arm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .arm_flag_i(flag_q[IDX_ARM]),
    .kick_o(kick), .refresh_o(refresh)
  );

  wdog_down_counter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .refresh_i(refresh),
    .running_o(running), .bite_o(wd_rst_o)
  );

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == ADDR_ARM) begin
      sfr_rdata           = en_arm_q;
      sfr_rdata[FLAG_POS] = flag_q[IDX_ARM];
    end else if (sfr_addr == ADDR_KICK) begin
      sfr_rdata           = en_kick_q;
      sfr_rdata[FLAG_POS] = flag_q[IDX_KICK];
    end
  end
endmodule

// File: rtl/wdog_refresh_chk.sv
module wdog_refresh_chk
  import wdog_pkg::*;
#(
  parameter int FLAG_HOLD = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_we,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic       wd_rst_o,
  input logic       arm_q,
  input logic       kick_q,
  input logic       running,
  input logic       refresh
);
  localparam int AW = $clog2(FLAG_HOLD + 1);
  logic [AW-1:0] age_arm, age_kick;
  logic          last_was_arm;
  logic          set_arm, set_kick;

  assign set_arm  = sfr_we && sfr_addr == ADDR_ARM  && sfr_wdata[FLAG_POS];
  assign set_kick = sfr_we && sfr_addr == ADDR_KICK && sfr_wdata[FLAG_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_arm      <= AW'(FLAG_HOLD);
      age_kick     <= AW'(FLAG_HOLD);
      last_was_arm <= 1'b0;
    end else begin
      if (set_arm) age_arm <= '0;
      else if (age_arm != AW'(FLAG_HOLD)) age_arm <= age_arm + 1'b1;
      if (set_kick) age_kick <= '0;
      else if (age_kick != AW'(FLAG_HOLD)) age_kick <= age_kick + 1'b1;
      if (sfr_we && (sfr_addr == ADDR_ARM || sfr_addr == ADDR_KICK))
        last_was_arm <= set_arm;
    end
  end

  assert_arm_lifetime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> (age_arm < AW'(FLAG_HOLD)));

  assert_kick_lifetime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> (age_kick < AW'(FLAG_HOLD)));

  assert_refresh_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (last_was_arm && arm_q));

  assert_stop_only_on_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> wd_rst_o);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |=> !wd_rst_o);
endmodule

bind wdog_refresh_ctrl wdog_refresh_chk #(.FLAG_HOLD(FLAG_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .wd_rst_o(wd_rst_o),
  .arm_q(flag_q[wdog_pkg::IDX_ARM]), .kick_q(flag_q[wdog_pkg::IDX_KICK]),
  .running(running), .refresh(refresh)
);

// File: tb/wdog_refresh_ctrl_test.sv
module wdog_refresh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int HOLD       = 12;
  localparam logic [7:0] A  = 8'hA8;
  localparam logic [7:0] B  = 8'hB8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic       wd_rst_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_refresh_ctrl #(.CNT_W(16), .TIMEOUT(TMO), .FLAG_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .wd_rst_o(wd_rst_o)
  );

  always_ff @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // monitor: every reset pulse must match the next expected edge number
  always @(negedge clk) begin
    if (rst_n && wd_rst_o) begin
      if (exp_q.size() == 0) chk("R7/R8/R9/R11 unexpected pulse", cyc, -1);
      else chk("R5/R6 pulse edge", cyc, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] ad, input logic [7:0] d, output int at);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = ad; sfr_wdata = d;
    @(posedge clk);
    #1;
    at = cyc;
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, input logic [7:0] exp, input string req);
    @(negedge clk);
    sfr_addr = ad;
    #1;
    chk(req, sfr_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic run_all();
    int k0, k1, ka;
    // R1 reset state
    rd(A, 8'h00, "R1 reg A");
    rd(B, 8'h00, "R1 reg B");
    chk("R1 reset output", wd_rst_o, 0);
    // R2 storage and reserved bits
    wr(A, 8'h9F, k0); rd(A, 8'h9F, "R2 A enables");
    wr(A, 8'hBF, k0); rd(A, 8'h9F, "R2 A bit5 zero");
    wr(B, 8'hBF, k0); rd(B, 8'h3E, "R2 B bits 7,0 zero");
    rd(8'h10, 8'h00, "R2 other address");
    // R3 arm flag lifetime (idle counter: no effect)
    wr(A, 8'hDF, k0);
    idle(11); rd(A, 8'hDF, "R3 arm still set");
    @(posedge clk); rd(A, 8'h9F, "R3 arm self-cleared");
    // R4/R5 kick starts idle counter; R11 single pulse afterwards
    wr(B, 8'h7E, k0); exp_q.push_back(k0 + TMO + 1);
    idle(11); rd(B, 8'h7E, "R4 kick still set");
    @(posedge clk); rd(B, 8'h3E, "R4 kick self-cleared");
    idle(TMO + 20);
    // R7 lone kick while running; R10 clearing flags has no effect
    wr(B, 8'h7E, k0); exp_q.push_back(k0 + TMO + 1);
    idle(8); wr(B, 8'h7E, k1);
    idle(3); wr(A, 8'h00, k1); wr(B, 8'h3E, k1);
    idle(TMO + 10);
    // R6 proper sequences: back-to-back, then with a gap
    wr(B, 8'h7E, k0);
    idle(18); wr(A, 8'h40, ka); wr(B, 8'h40, k1);
    idle(8); wr(A, 8'h40, ka); idle(3); wr(B, 8'h40, k1);
    exp_q.push_back(k1 + TMO + 1);
    idle(TMO + 10);
    // R8 intervening write cancels
    wr(B, 8'h7E, k0); exp_q.push_back(k0 + TMO + 1);
    idle(5); wr(A, 8'h40, ka); wr(B, 8'h3E, k1); wr(B, 8'h7E, k1);
    idle(TMO + 10);
    // R9 stale arm rejected
    wr(B, 8'h7E, k0); exp_q.push_back(k0 + TMO + 1);
    idle(2); wr(A, 8'h40, ka);
    idle(13); rd(A, 8'h00, "R9 arm cleared before kick");
    wr(B, 8'h7E, k1);
    idle(TMO + 10);
    chk("R5/R6 pending pulses", exp_q.size(), 0);
    chk("R11 output low at end", wd_rst_o, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    fork
      run_all();
      begin
        idle(20000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule